// File: doc/BRIEF.md
# PPP HDLC Transmit Framer

This block turns packets arriving one byte at a time into HDLC-like PPP frames for a byte-wide line interface. Each frame starts with a flag octet. A header follows, made of an address byte, a control byte and a protocol field. The payload comes next, then a frame check sequence and a closing flag. Every octet between the flags goes through octet-transparency escaping. The finished byte stream can then pass through an optional self-synchronous scrambler before it leaves the block.

The packet side is a pull interface. The block raises a request, and a byte is accepted on any clock edge where both the request and the valid input are high. The packet source marks the last payload byte with a boundary input. If it also raises the abort input with that byte, the frame is cut off and no check sequence is sent. Three counters report how many frames were sent, how many of them were oversize, and how many transmit breaks occurred. All settings are static inputs. They may change only while the synchronous soft reset is held.

Top module: `ppp_tx_framer`

## Requirements
- R1: After reset, with no packet pending, the block sends the flag 0x7E on every cycle with `phy_en` high. `pkt_req` stays low and all counters read zero.
- R2: When `cfg_hdr_comp` is 0, the frame body starts with `cfg_addr` and then `cfg_ctrl`. When it is 1, both bytes are left out.
- R3: With `cfg_proto16`=1, the protocol field is `cfg_proto[15:8]` followed by `cfg_proto[7:0]`. If `cfg_proto_comp` is also 1, only `cfg_proto[15:8]` is sent. With `cfg_proto16`=0, only `cfg_proto[7:0]` is sent.
- R4: Right after the byte marked last, the block sends the complemented CRC of all header and payload octets, least significant byte first, and then a closing flag. The CRC uses reflected bit order and an all-ones preset. With `cfg_fcs32`=0 it is 16 bits wide, with polynomial 0x1021. With `cfg_fcs32`=1 it is 32 bits wide, with polynomial 0x04C11DB7.
- R5: Any header, payload or FCS octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20. As a result, no 0x7E appears inside a frame body.
- R6: With `cfg_scr_en`=1, each output bit, taken least significant first, is the input bit XOR the output bit sent 43 bits earlier. The scrambler history is zero after any reset. With `cfg_scr_en`=0, the bytes pass through unchanged.
- R7: A payload byte is taken only on an edge where `pkt_req` and `pkt_valid` are both high. `pkt_req` is low while the second byte of an escape pair is being produced. A payload cycle in which `pkt_valid` is low produces no PHY byte.
- R8: If `pkt_abort` is high together with the last byte, that byte is dropped and no FCS is sent. The frame ends with 0x7D and then 0x7E. `cnt_break` increments by one and `cnt_sent` does not change.
- R9: `cnt_sent` increments when the closing flag of a frame that was not aborted is produced. `cnt_oversize` increments at the same point when the payload length is greater than `cfg_max_len`. A length equal to `cfg_max_len` is not oversize.
- R10: While `soft_rst` is high, `phy_en` is low from the next cycle on, and the counters, the frame state and the scrambler history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous reset, active high; configuration may change only while it is high |
| cfg_addr | input | 8 | Address field value |
| cfg_ctrl | input | 8 | Control field value |
| cfg_proto | input | 16 | Protocol field value |
| cfg_proto16 | input | 1 | 1: 16-bit protocol field, 0: 8-bit |
| cfg_hdr_comp | input | 1 | Leave out address and control fields |
| cfg_proto_comp | input | 1 | Send only the high protocol byte in 16-bit mode |
| cfg_fcs32 | input | 1 | 1: 32-bit FCS, 0: 16-bit FCS |
| cfg_scr_en | input | 1 | Enable the x^43+1 scrambler |
| cfg_max_len | input | LEN_W | Largest payload length not counted as oversize |
| pkt_req | output | 1 | Requests the next payload byte |
| pkt_valid | input | 1 | Payload byte valid; when seen in idle, a packet is pending |
| pkt_data | input | 8 | Payload byte |
| pkt_last | input | 1 | Marks the last payload byte |
| pkt_abort | input | 1 | With `pkt_last`, aborts the frame |
| phy_en | output | 1 | `phy_data` carries a valid byte |
| phy_data | output | 8 | Line byte |
| cnt_sent | output | CNT_W | Frames sent |
| cnt_oversize | output | CNT_W | Frames with payload longer than `cfg_max_len` |
| cnt_break | output | CNT_W | Aborted frames |

## Verification
The checker verifies these rules on every cycle:
- soft reset silences the line;
- no byte is requested while an escape pair is in progress;
- no request follows the last byte directly;
- an abort always advances the break counter by exactly one;
- the oversize counter never moves without the sent counter;
- with scrambling off, each escaped byte reaches the line unchanged one cycle later.

The byte content of frames can only be shown by the bench's scenarios. This covers header compression variants, the 16- and 32-bit check sequences, escaping of flag and escape octets, the descrambled stream, payload gaps, the boundary between equal and excess length, aborts and back-to-back packets.

// File: rtl/ppp_tx_pkg.sv
package ppp_tx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CTRL,
      ST_PHI,
      ST_PLO,
      ST_DATA,
      ST_FCS,
      ST_ABORT,
      ST_CLOSE
   } fr_state_t;

   localparam logic [7:0] FLAG_OCT = 8'h7E;
   localparam logic [7:0] ESC_OCT  = 8'h7D;
   localparam logic [7:0] ESC_MASK = 8'h20;

   // mirror the lowest w bits of v
   function automatic logic [31:0] mirror_bits(input logic [31:0] v, input int w);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < w) r[i] = v[w-1-i];
      end
      return r;
   endfunction

endpackage

// File: rtl/ppp_tx_crc.sv
module ppp_tx_crc #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         en,
   input  logic [7:0]   data,
   output logic [W-1:0] fcs
);
   localparam logic [W-1:0] RPOLY = W'(ppp_tx_pkg::mirror_bits(32'(POLY), W));

   if (W != 16 && W != 32) begin : g_bad_w
      $error("ppp_tx_crc: W must be 16 or 32");
   end

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_d;

   always_comb begin
      crc_d = crc_q;
      for (int i = 0; i < 8; i++) begin
         if (crc_d[0] ^ data[i]) crc_d = (crc_d >> 1) ^ RPOLY;
         else                    crc_d = crc_d >> 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= '1;
      else if (init) crc_q <= '1;
      else if (en)   crc_q <= crc_d;
   end

   assign fcs = ~crc_q;
endmodule

// File: rtl/ppp_tx_escape.sv
module ppp_tx_escape (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   input  logic       in_raw,
   output logic       busy,
   output logic       out_valid,
   output logic [7:0] out_byte
);
   import ppp_tx_pkg::*;

   logic       pend_q;
   logic [7:0] pend_byte_q;
   logic       special;

   assign special = (in_byte == FLAG_OCT) || (in_byte == ESC_OCT);
   assign busy    = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_byte_q <= '0;
         out_valid   <= 1'b0;
         out_byte    <= '0;
      end else if (clr) begin
         pend_q      <= 1'b0;
         out_valid   <= 1'b0;
      end else if (pend_q) begin
         out_valid   <= 1'b1;
         out_byte    <= pend_byte_q;
         pend_q      <= 1'b0;
      end else if (in_valid) begin
         out_valid   <= 1'b1;
         if (!in_raw && special) begin
            out_byte    <= ESC_OCT;
            pend_byte_q <= in_byte ^ ESC_MASK;
            pend_q      <= 1'b1;
         end else begin
            out_byte    <= in_byte;
         end
      end else begin
         out_valid   <= 1'b0;
      end
   end
endmodule

// File: rtl/ppp_tx_scram.sv
module ppp_tx_scram #(
   parameter int TAP = 43
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       enable,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   output logic       out_valid,
   output logic [7:0] out_byte
);
   if (TAP < 9) begin : g_bad_tap
      $error("ppp_tx_scram: TAP must exceed one byte");
   end

   logic [TAP-1:0] hist_q;
   logic [TAP-1:0] hist_d;
   logic [7:0]     scr_d;

   always_comb begin
      hist_d = hist_q;
      for (int i = 0; i < 8; i++) begin
         scr_d[i] = in_byte[i] ^ (enable & hist_d[TAP-1]);
         hist_d   = {hist_d[TAP-2:0], scr_d[i]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q    <= '0;
         out_valid <= 1'b0;
         out_byte  <= '0;
      end else if (clr) begin
         hist_q    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_byte <= scr_d;
            hist_q   <= hist_d;
         end
      end
   end
endmodule

// File: rtl/ppp_tx_framer.sv
module ppp_tx_framer #(
   parameter int CNT_W    = 16,
   parameter int LEN_W    = 16,
   parameter int FCS32_EN = 1,
   parameter int SCR_TAP  = 43
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [7:0]       cfg_addr,
   input  logic [7:0]       cfg_ctrl,
   input  logic [15:0]      cfg_proto,
   input  logic             cfg_proto16,
   input  logic             cfg_hdr_comp,
   input  logic             cfg_proto_comp,
   input  logic             cfg_fcs32,
   input  logic             cfg_scr_en,
   input  logic [LEN_W-1:0] cfg_max_len,
   output logic             pkt_req,
   input  logic             pkt_valid,
   input  logic [7:0]       pkt_data,
   input  logic             pkt_last,
   input  logic             pkt_abort,
   output logic             phy_en,
   output logic [7:0]       phy_data,
   output logic [CNT_W-1:0] cnt_sent,
   output logic [CNT_W-1:0] cnt_oversize,
   output logic [CNT_W-1:0] cnt_break
);
   import ppp_tx_pkg::*;

   if (CNT_W < 1 || LEN_W < 2) begin : g_bad_width
      $error("ppp_tx_framer: counter and length widths too small");
   end

   localparam logic [LEN_W-1:0] LEN_MAX = '1;

   fr_state_t        state_q, nxt;
   logic [1:0]       fcs_idx_q;
   logic [LEN_W-1:0] len_q;
   logic             aborted_q;

   logic       esc_busy, esc_vld;
   logic [7:0] esc_byte;
   logic       adv;

   logic       fr_valid, fr_raw;
   logic [7:0] fr_byte;
   logic       crc_init, crc_en, take, abort_hit;

   logic [15:0] fcs16;
   logic [31:0] fcs32;
   logic        use32;
   logic [31:0] fcs_sel;
   logic [1:0]  fcs_last;
   fr_state_t   first_hdr;

   assign adv      = !esc_busy;
   assign use32    = (FCS32_EN != 0) && cfg_fcs32;
   assign fcs_sel  = use32 ? fcs32 : {16'h0000, fcs16};
   assign fcs_last = use32 ? 2'd3 : 2'd1;
   assign pkt_req  = (state_q == ST_DATA) && adv && !soft_rst;

   always_comb begin
      if (!cfg_hdr_comp)   first_hdr = ST_ADDR;
      else if (cfg_proto16) first_hdr = ST_PHI;
      else                 first_hdr = ST_PLO;
   end

   // frame sequencer: one raw octet per advance
   always_comb begin
      nxt       = state_q;
      fr_valid  = 1'b0;
      fr_raw    = 1'b1;
      fr_byte   = FLAG_OCT;
      crc_init  = 1'b0;
      crc_en    = 1'b0;
      take      = 1'b0;
      abort_hit = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            fr_valid = 1'b1;
            crc_init = 1'b1;
            if (pkt_valid) nxt = first_hdr;
         end
         ST_ADDR: begin
            fr_valid = 1'b1;
            fr_raw   = 1'b0;
            fr_byte  = cfg_addr;
            crc_en   = 1'b1;
            nxt      = ST_CTRL;
         end
         ST_CTRL: begin
            fr_valid = 1'b1;
            fr_raw   = 1'b0;
            fr_byte  = cfg_ctrl;
            crc_en   = 1'b1;
            nxt      = cfg_proto16 ? ST_PHI : ST_PLO;
         end
         ST_PHI: begin
            fr_valid = 1'b1;
            fr_raw   = 1'b0;
            fr_byte  = cfg_proto[15:8];
            crc_en   = 1'b1;
            nxt      = cfg_proto_comp ? ST_DATA : ST_PLO;
         end
         ST_PLO: begin
            fr_valid = 1'b1;
            fr_raw   = 1'b0;
            fr_byte  = cfg_proto[7:0];
            crc_en   = 1'b1;
            nxt      = ST_DATA;
         end
         ST_DATA: begin
            if (pkt_valid) begin
               take = 1'b1;
               if (pkt_last && pkt_abort) begin
                  abort_hit = 1'b1;
                  nxt       = ST_ABORT;
               end else begin
                  fr_valid = 1'b1;
                  fr_raw   = 1'b0;
                  fr_byte  = pkt_data;
                  crc_en   = 1'b1;
                  if (pkt_last) nxt = ST_FCS;
               end
            end
         end
         ST_FCS: begin
            fr_valid = 1'b1;
            fr_raw   = 1'b0;
            fr_byte  = fcs_sel[8*fcs_idx_q +: 8];
            if (fcs_idx_q == fcs_last) nxt = ST_CLOSE;
         end
         ST_ABORT: begin
            fr_valid = 1'b1;
            fr_byte  = ESC_OCT;
            nxt      = ST_CLOSE;
         end
         ST_CLOSE: begin
            fr_valid = 1'b1;
            nxt      = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         fcs_idx_q    <= '0;
         len_q        <= '0;
         aborted_q    <= 1'b0;
         cnt_sent     <= '0;
         cnt_oversize <= '0;
         cnt_break    <= '0;
      end else if (soft_rst) begin
         state_q      <= ST_IDLE;
         fcs_idx_q    <= '0;
         len_q        <= '0;
         aborted_q    <= 1'b0;
         cnt_sent     <= '0;
         cnt_oversize <= '0;
         cnt_break    <= '0;
      end else if (adv) begin
         state_q   <= nxt;
         fcs_idx_q <= (state_q == ST_FCS) ? fcs_idx_q + 2'd1 : 2'd0;
         if (state_q == ST_IDLE) begin
            len_q     <= '0;
            aborted_q <= 1'b0;
         end
         if (take && !abort_hit && len_q != LEN_MAX) len_q <= len_q + 1'b1;
         if (abort_hit) begin
            aborted_q <= 1'b1;
            cnt_break <= cnt_break + 1'b1;
         end
         if (state_q == ST_CLOSE && !aborted_q) begin
            cnt_sent <= cnt_sent + 1'b1;
            if (len_q > cfg_max_len) cnt_oversize <= cnt_oversize + 1'b1;
         end
      end
   end

   ppp_tx_crc #(.W(16), .POLY(16'h1021)) i_crc16 (
      .clk  (clk),
      .rst_n(rst_n),
      .init (soft_rst || (crc_init && adv)),
      .en   (crc_en && adv),
      .data (fr_byte),
      .fcs  (fcs16)
   );

   if (FCS32_EN != 0) begin : g_crc32
      ppp_tx_crc #(.W(32), .POLY(32'h04C11DB7)) i_crc32 (
         .clk  (clk),
         .rst_n(rst_n),
         .init (soft_rst || (crc_init && adv)),
         .en   (crc_en && adv),
         .data (fr_byte),
         .fcs  (fcs32)
      );
   end else begin : g_no_crc32
      assign fcs32 = '0;
   end

   ppp_tx_escape i_esc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .in_valid (fr_valid && adv && !soft_rst),
      .in_byte  (fr_byte),
      .in_raw   (fr_raw),
      .busy     (esc_busy),
      .out_valid(esc_vld),
      .out_byte (esc_byte)
   );

   ppp_tx_scram #(.TAP(SCR_TAP)) i_scr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .enable   (cfg_scr_en),
      .in_valid (esc_vld),
      .in_byte  (esc_byte),
      .out_valid(phy_en),
      .out_byte (phy_data)
   );
endmodule

// File: rtl/ppp_tx_framer_chk.sv
module ppp_tx_framer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             cfg_scr_en,
   input logic             pkt_req,
   input logic             pkt_valid,
   input logic             pkt_last,
   input logic             pkt_abort,
   input logic             phy_en,
   input logic [7:0]       phy_data,
   input logic [CNT_W-1:0] cnt_sent,
   input logic [CNT_W-1:0] cnt_oversize,
   input logic [CNT_W-1:0] cnt_break,
   input logic             esc_busy,
   input logic             esc_vld,
   input logic [7:0]       esc_byte
);
   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !phy_en); // R10

   AST_REQ_ESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      esc_busy |-> !pkt_req); // R7

   AST_LAST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_req && pkt_valid && pkt_last) |=> !pkt_req); // R4

   AST_BREAK_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_req && pkt_valid && pkt_last && pkt_abort)
      |=> (cnt_break == $past(cnt_break) + CNT_W'(1))); // R8

   AST_BREAK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(soft_rst) && cnt_break != $past(cnt_break))
      |-> (cnt_break == $past(cnt_break) + CNT_W'(1))); // R8

   AST_OVS_WITH_SENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(soft_rst) && cnt_oversize != $past(cnt_oversize))
      |-> (cnt_sent != $past(cnt_sent))); // R9

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_scr_en) && !$past(soft_rst) && $past(esc_vld))
      |-> (phy_en && phy_data == $past(esc_byte))); // R6
endmodule

bind ppp_tx_framer ppp_tx_framer_chk #(.CNT_W(CNT_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .soft_rst    (soft_rst),
   .cfg_scr_en  (cfg_scr_en),
   .pkt_req     (pkt_req),
   .pkt_valid   (pkt_valid),
   .pkt_last    (pkt_last),
   .pkt_abort   (pkt_abort),
   .phy_en      (phy_en),
   .phy_data    (phy_data),
   .cnt_sent    (cnt_sent),
   .cnt_oversize(cnt_oversize),
   .cnt_break   (cnt_break),
   .esc_busy    (esc_busy),
   .esc_vld     (esc_vld),
   .esc_byte    (esc_byte)
);

// File: tb/test_ppp_tx_framer.sv
module test_ppp_tx_framer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [7:0]  cfg_addr = 8'hFF;
   logic [7:0]  cfg_ctrl = 8'h03;
   logic [15:0] cfg_proto = 16'h7E21;
   logic        cfg_proto16 = 1'b0;
   logic        cfg_hdr_comp = 1'b0;
   logic        cfg_proto_comp = 1'b0;
   logic        cfg_fcs32 = 1'b0;
   logic        cfg_scr_en = 1'b0;
   logic [15:0] cfg_max_len = 16'd0;
   logic        pkt_req;
   logic        pkt_valid = 1'b0;
   logic [7:0]  pkt_data = 8'h00;
   logic        pkt_last = 1'b0;
   logic        pkt_abort = 1'b0;
   logic        phy_en;
   logic [7:0]  phy_data;
   logic [15:0] cnt_sent, cnt_oversize, cnt_break;

   int checks = 0;
   int fails  = 0;

   logic [7:0] cap_q[$];
   logic [7:0] raw_q[$];
   logic [7:0] exp_q[$];
   logic [7:0] obs_q[$];

   always #5 clk = ~clk;

   ppp_tx_framer i_ppp_tx_framer (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl), .cfg_proto(cfg_proto),
      .cfg_proto16(cfg_proto16), .cfg_hdr_comp(cfg_hdr_comp),
      .cfg_proto_comp(cfg_proto_comp), .cfg_fcs32(cfg_fcs32),
      .cfg_scr_en(cfg_scr_en), .cfg_max_len(cfg_max_len),
      .pkt_req(pkt_req), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .pkt_last(pkt_last), .pkt_abort(pkt_abort),
      .phy_en(phy_en), .phy_data(phy_data),
      .cnt_sent(cnt_sent), .cnt_oversize(cnt_oversize), .cnt_break(cnt_break)
   );

   typedef struct packed {
      logic        hdr_comp;
      logic        proto_comp;
      logic        proto16;
      logic        fcs32;
      logic        scr;
      logic        gaps;
      logic [15:0] max_len;
      logic [3:0]  len;
      logic [63:0] payload;
      logic        exp_ovs;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd10, 4'd4, 64'h04030201,   1'b0},
      '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd2,  4'd3, 64'h557D7E,     1'b1},
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd1,  4'd1, 64'h7D,         1'b0},
      '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd4,  4'd5, 64'h7E99887766, 1'b1},
      '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd8,  4'd2, 64'h5D20,       1'b0}
   };

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (phy_en) cap_q.push_back(phy_data);
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   // expected frame body after escaping, with all flags removed (appended to exp_q)
   task automatic build_exp(input int len, input logic [63:0] pl, input bit ab);
      logic [31:0] c;
      int nb;
      raw_q.delete();
      if (!cfg_hdr_comp) begin
         raw_q.push_back(cfg_addr);
         raw_q.push_back(cfg_ctrl);
      end
      if (cfg_proto16) begin
         raw_q.push_back(cfg_proto[15:8]);
         if (!cfg_proto_comp) raw_q.push_back(cfg_proto[7:0]);
      end else begin
         raw_q.push_back(cfg_proto[7:0]);
      end
      nb = ab ? len - 1 : len;
      for (int i = 0; i < nb; i++) raw_q.push_back(pl[8*i +: 8]);
      if (!ab) begin
         c = cfg_fcs32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
         foreach (raw_q[k]) begin
            for (int i = 0; i < 8; i++) begin
               bit fb;
               fb = c[0] ^ raw_q[k][i];
               c  = c >> 1;
               if (fb) c = c ^ (cfg_fcs32 ? 32'hEDB8_8320 : 32'h0000_8408);
            end
         end
         c = ~c;
         for (int i = 0; i < (cfg_fcs32 ? 4 : 2); i++) raw_q.push_back(c[8*i +: 8]);
      end
      foreach (raw_q[k]) begin
         if (raw_q[k] == 8'h7E || raw_q[k] == 8'h7D) begin
            exp_q.push_back(8'h7D);
            exp_q.push_back(raw_q[k] ^ 8'h20);
         end else begin
            exp_q.push_back(raw_q[k]);
         end
      end
      if (ab) exp_q.push_back(8'h7D);
   endtask

   task automatic cmp_frame(input string req);
      logic [42:0] hist;
      logic [7:0]  d;
      int bad;
      hist = '0;
      obs_q.delete();
      foreach (cap_q[k]) begin
         if (cfg_scr_en) begin
            for (int i = 0; i < 8; i++) begin
               d[i] = cap_q[k][i] ^ hist[42];
               hist = {hist[41:0], cap_q[k][i]};
            end
         end else begin
            d = cap_q[k];
         end
         if (d != 8'h7E) obs_q.push_back(d);
      end
      checks++;
      bad = -1;
      if (obs_q.size() != exp_q.size()) bad = 0;
      else foreach (exp_q[k]) if (bad < 0 && obs_q[k] !== exp_q[k]) bad = k;
      if (bad >= 0) begin
         fails++;
         if (obs_q.size() != exp_q.size())
            $display("FAIL %s frame length actual=%0d expected=%0d", req, obs_q.size(), exp_q.size());
         else
            $display("FAIL %s byte %0d actual=%0h expected=%0h", req, bad, obs_q[bad], exp_q[bad]);
      end
   endtask

   // called at a negedge; returns at a negedge
   task automatic send_pkt(input int len, input logic [63:0] pl, input bit ab, input bit gaps);
      for (int i = 0; i < len; i++) begin
         if (gaps && i == 1) begin
            pkt_valid = 1'b0;
            repeat (2) @(negedge clk);
         end
         pkt_valid = 1'b1;
         pkt_data  = pl[8*i +: 8];
         pkt_last  = (i == len - 1);
         pkt_abort = ab && (i == len - 1);
         #1;
         while (!pkt_req) begin
            @(negedge clk);
            #1;
         end
         @(negedge clk);
      end
      pkt_valid = 1'b0;
      pkt_last  = 1'b0;
      pkt_abort = 1'b0;
   endtask

   task automatic apply_cfg(input vec_t v);
      @(negedge clk);
      soft_rst       = 1'b1;
      cfg_hdr_comp   = v.hdr_comp;
      cfg_proto_comp = v.proto_comp;
      cfg_proto16    = v.proto16;
      cfg_fcs32      = v.fcs32;
      cfg_scr_en     = v.scr;
      cfg_max_len    = v.max_len;
      repeat (2) @(negedge clk);
      cap_q.delete();
      soft_rst = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      #12;
      chk("R1 reset pkt_req", pkt_req, 0);
      chk("R1 reset phy_en", phy_en, 0);
      chk("R1 reset counters", {cnt_sent, cnt_oversize}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 idle flag enable", phy_en, 1);
      chk("R1 idle flag value", phy_data, 8'h7E);
      chk("R1 idle no request", pkt_req, 0);

      // vector table: R2 R3 R4 R5 R6 R7 R9
      for (int v = 0; v < NV; v++) begin
         apply_cfg(VEC[v]);
         exp_q.delete();
         build_exp(int'(VEC[v].len), VEC[v].payload, 1'b0);
         send_pkt(int'(VEC[v].len), VEC[v].payload, 1'b0, VEC[v].gaps);
         repeat (30) @(negedge clk);
         cmp_frame($sformatf("R2 R3 R4 R5 R6 R7 frame vec%0d", v));
         chk($sformatf("R9 sent vec%0d", v), cnt_sent, 1);
         chk($sformatf("R9 oversize vec%0d", v), cnt_oversize, 32'(VEC[v].exp_ovs));
         chk($sformatf("R8 no break vec%0d", v), cnt_break, 0);
      end

      // R8: abort with last byte
      apply_cfg(VEC[0]);
      exp_q.delete();
      build_exp(3, 64'h0C0B0A, 1'b1);
      send_pkt(3, 64'h0C0B0A, 1'b1, 1'b0);
      repeat (30) @(negedge clk);
      cmp_frame("R8 abort frame");
      chk("R8 break count", cnt_break, 1);
      chk("R8 sent unchanged", cnt_sent, 0);

      // R9: back-to-back packets, equal-to-max is not oversize
      apply_cfg(VEC[2]);
      exp_q.delete();
      build_exp(1, 64'h7D, 1'b0);
      build_exp(1, 64'h11, 1'b0);
      send_pkt(1, 64'h7D, 1'b0, 1'b0);
      send_pkt(1, 64'h11, 1'b0, 1'b0);
      repeat (30) @(negedge clk);
      cmp_frame("R4 R9 back to back frames");
      chk("R9 two sent", cnt_sent, 2);
      chk("R9 none oversize", cnt_oversize, 0);

      // R10: soft reset clears and silences
      @(negedge clk);
      soft_rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 phy_en low", phy_en, 0);
      chk("R10 counters cleared", {cnt_sent, cnt_break}, 0);
      chk("R10 no request", pkt_req, 0);
      soft_rst = 1'b0;
      repeat (3) @(negedge clk);

      finish_run();
   end
endmodule